// File: doc/BRIEF.md
# Translation Lookaside Buffer with Pinned Entry Region

This block caches virtual-to-physical page translations in two separate stores that are searched together. The larger store is a 2-way, 16-set associative array, indexed by the low bits of the virtual page number and replaced round-robin within each set. The smaller store has eight fully associative slots. Software can pin translations there so that bulk flushes do not remove them.

A software-written placement register decides where each refill from the page-table walker is written. The refill arrives as a complete entry: virtual page, physical page and attributes. With the placement flag clear, the refill goes into the associative array. With the flag set, it goes into the pinned slot named by the register's victim field. The victim field does not move on by itself, so software rewrites it to choose the next slot.

A flush-all command empties only the associative array. A flush-by-address command removes every entry that matches the given virtual page, in either store. A lookup completes in the same cycle and returns hit, physical page and attributes.

Top module: `tlb_lockdown`

## Requirements
- R1: After reset no lookup hits, the placement flag is 0, the victim field is 0, and `reg_rdata` reads all zero.
- R2: A write with `reg_we` stores `reg_wdata[0]` as the placement flag and `reg_wdata[28:26]` as the victim slot. `reg_rdata` returns those two fields at the same positions and zero in every other bit, from the cycle after the write.
- R3: With the placement flag 0, a refill is written into set `fill_vpn[3:0]` of the associative array, at the way given by that set's round-robin pointer. The pointer starts at way 0 and advances after each refill into that set, so the third refill into one set evicts the first.
- R4: With the placement flag 1, a refill is written into the pinned slot given by the victim field. It overwrites that slot even when the slot already holds a valid entry, and it leaves the associative array unchanged.
- R5: A pinned refill does not change the victim field. `reg_rdata` stays the same until software writes it.
- R6: `inv_all` clears every entry of the associative array and leaves every pinned entry valid.
- R7: `inv_va_en` clears every entry in either store whose virtual page equals `inv_vpn`.
- R8: A lookup is combinational. `lkp_hit` is set when either store matches `lkp_vpn`. A pinned match takes priority over an associative match, the lowest-numbered matching slot wins among pinned slots, and the lowest-numbered matching way wins in the array.
- R9: When commands coincide in one cycle, invalidations are applied before the refill, so the refilled entry stays valid. A refill placed in the same cycle as a register write follows the register value from before that write.
- R10: Refills into the associative array never remove or alter a pinned entry, however many refills land in the same set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_vpn | input | 20 | Virtual page number to translate |
| lkp_hit | output | 1 | Translation found |
| lkp_ppn | output | 20 | Physical page of the hit |
| lkp_attr | output | 8 | Attributes of the hit |
| fill_en | input | 1 | Write a refill entry |
| fill_vpn | input | 20 | Refill virtual page |
| fill_ppn | input | 20 | Refill physical page |
| fill_attr | input | 8 | Refill attributes |
| inv_all | input | 1 | Flush the associative array |
| inv_va_en | input | 1 | Flush entries that match `inv_vpn` |
| inv_vpn | input | 20 | Virtual page to flush |
| reg_we | input | 1 | Write the placement register |
| reg_wdata | input | 32 | Placement register write data |
| reg_rdata | output | 32 | Placement register read data |

## Verification
The assertions check several properties on every cycle. A pinned hit always drives the physical page output. A flush-all empties the array and leaves the pinned valid bits unchanged. A flushed address misses on the next cycle. A refill is visible on the next cycle. Refills leave the register unchanged, and register readback exposes only the two defined fields.

Some behaviours need a history of operations, so only the bench scenarios can show them. These are the round-robin eviction order within a set, unconditional overwrite of an occupied pinned slot, ordering between commands in the same cycle, and pinned entries surviving heavy pressure on one set.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   // Placement register layout; the block decodes these positions.
   localparam int unsigned CTRL_W       = 32;
   localparam int unsigned PLACE_BIT    = 0;
   localparam int unsigned VICTIM_LSB   = 26;
   localparam int unsigned VICTIM_MAX_W = CTRL_W - VICTIM_LSB;
endpackage

// File: rtl/tlb_lock_ctrl.sv
module tlb_lock_ctrl
   import tlb_pkg::*;
#(
   parameter int unsigned VIC_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CTRL_W-1:0] wdata,
   output logic              place_ld,
   output logic [VIC_W-1:0]  victim,
   output logic [CTRL_W-1:0] rdata
);
   logic unused_wbits;
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         place_ld <= 1'b0;
         victim   <= '0;
      end else if (we) begin
         place_ld <= wdata[PLACE_BIT];
         victim   <= wdata[VICTIM_LSB +: VIC_W];
      end
   end

   always_comb begin
      rdata                        = '0;
      rdata[PLACE_BIT]             = place_ld;
      rdata[VICTIM_LSB +: VIC_W]   = victim;
   end
endmodule

// File: rtl/tlb_sa_region.sv
module tlb_sa_region #(
   parameter int unsigned VPN_W  = 20,
   parameter int unsigned PPN_W  = 20,
   parameter int unsigned ATTR_W = 8,
   parameter int unsigned WAYS   = 2,
   parameter int unsigned SETS   = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [VPN_W-1:0]       lkp_vpn,
   output logic                   hit,
   output logic [PPN_W-1:0]       ppn,
   output logic [ATTR_W-1:0]      attr,
   input  logic                   fill_en,
   input  logic [VPN_W-1:0]       fill_vpn,
   input  logic [PPN_W-1:0]       fill_ppn,
   input  logic [ATTR_W-1:0]      fill_attr,
   input  logic                   inv_all,
   input  logic                   inv_va_en,
   input  logic [VPN_W-1:0]       inv_vpn,
   output logic [WAYS*SETS-1:0]   valid_flat
);
   localparam int unsigned IDX_W = $clog2(SETS);
   localparam int unsigned TAG_W = VPN_W - IDX_W;
   localparam int unsigned PTR_W = (WAYS > 1) ? $clog2(WAYS) : 1;

   logic [IDX_W-1:0] l_idx, f_idx, i_idx;
   logic [TAG_W-1:0] l_tag, f_tag, i_tag;
   assign l_idx = lkp_vpn[IDX_W-1:0];
   assign l_tag = lkp_vpn[VPN_W-1:IDX_W];
   assign f_idx = fill_vpn[IDX_W-1:0];
   assign f_tag = fill_vpn[VPN_W-1:IDX_W];
   assign i_idx = inv_vpn[IDX_W-1:0];
   assign i_tag = inv_vpn[VPN_W-1:IDX_W];

   logic [WAYS-1:0]   way_hit;
   logic [WAYS-1:0]   way_inv;
   logic [PPN_W-1:0]  way_ppn  [WAYS];
   logic [ATTR_W-1:0] way_attr [WAYS];
   logic [PTR_W-1:0]  rr_q     [SETS];
   logic [PTR_W-1:0]  fill_way;

   assign fill_way = rr_q[f_idx];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [SETS-1:0]   vld_q;
      logic [TAG_W-1:0]  tag_q  [SETS];
      logic [PPN_W-1:0]  ppn_q  [SETS];
      logic [ATTR_W-1:0] attr_q [SETS];
      logic              wr;

      assign wr          = fill_en && (fill_way == PTR_W'(w));
      assign way_hit[w]  = vld_q[l_idx] && (tag_q[l_idx] == l_tag);
      assign way_inv[w]  = vld_q[i_idx] && (tag_q[i_idx] == i_tag);
      assign way_ppn[w]  = ppn_q[l_idx];
      assign way_attr[w] = attr_q[l_idx];
      assign valid_flat[w*SETS +: SETS] = vld_q;

      // Invalidations first, then the refill, so a same-cycle refill survives.
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= '0;
         end else begin
            if (inv_all)                       vld_q        <= '0;
            else if (inv_va_en && way_inv[w])  vld_q[i_idx] <= 1'b0;
            if (wr)                            vld_q[f_idx] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (wr) begin
            tag_q[f_idx]  <= f_tag;
            ppn_q[f_idx]  <= fill_ppn;
            attr_q[f_idx] <= fill_attr;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
      end else if (fill_en) begin
         rr_q[f_idx] <= (fill_way == PTR_W'(WAYS-1)) ? '0 : fill_way + PTR_W'(1);
      end
   end

   always_comb begin
      hit  = |way_hit;
      ppn  = '0;
      attr = '0;
      for (int w = WAYS-1; w >= 0; w--) begin
         if (way_hit[w]) begin
            ppn  = way_ppn[w];
            attr = way_attr[w];
         end
      end
   end
endmodule

// File: rtl/tlb_ld_region.sv
module tlb_ld_region #(
   parameter int unsigned VPN_W   = 20,
   parameter int unsigned PPN_W   = 20,
   parameter int unsigned ATTR_W  = 8,
   parameter int unsigned ENTRIES = 8,
   localparam int unsigned SLOT_W = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [VPN_W-1:0]   lkp_vpn,
   output logic               hit,
   output logic [PPN_W-1:0]   ppn,
   output logic [ATTR_W-1:0]  attr,
   input  logic               fill_en,
   input  logic [SLOT_W-1:0]  fill_slot,
   input  logic [VPN_W-1:0]   fill_vpn,
   input  logic [PPN_W-1:0]   fill_ppn,
   input  logic [ATTR_W-1:0]  fill_attr,
   input  logic               inv_va_en,
   input  logic [VPN_W-1:0]   inv_vpn,
   output logic [ENTRIES-1:0] valid
);
   logic [ENTRIES-1:0] slot_hit;
   logic [PPN_W-1:0]   slot_ppn  [ENTRIES];
   logic [ATTR_W-1:0]  slot_attr [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      logic              vld_q;
      logic [VPN_W-1:0]  vpn_q;
      logic [PPN_W-1:0]  ppn_q;
      logic [ATTR_W-1:0] attr_q;
      logic              wr;

      assign wr           = fill_en && (fill_slot == SLOT_W'(e));
      assign slot_hit[e]  = vld_q && (vpn_q == lkp_vpn);
      assign slot_ppn[e]  = ppn_q;
      assign slot_attr[e] = attr_q;
      assign valid[e]     = vld_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
         end else begin
            if (inv_va_en && vld_q && (vpn_q == inv_vpn)) vld_q <= 1'b0;
            if (wr)                                       vld_q <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (wr) begin
            vpn_q  <= fill_vpn;
            ppn_q  <= fill_ppn;
            attr_q <= fill_attr;
         end
      end
   end

   always_comb begin
      hit  = |slot_hit;
      ppn  = '0;
      attr = '0;
      for (int e = ENTRIES-1; e >= 0; e--) begin
         if (slot_hit[e]) begin
            ppn  = slot_ppn[e];
            attr = slot_attr[e];
         end
      end
   end
endmodule

// File: rtl/tlb_lockdown.sv
module tlb_lockdown
   import tlb_pkg::*;
#(
   parameter int unsigned VPN_W      = 20,
   parameter int unsigned PPN_W      = 20,
   parameter int unsigned ATTR_W     = 8,
   parameter int unsigned SA_WAYS    = 2,
   parameter int unsigned SA_SETS    = 16,
   parameter int unsigned LD_ENTRIES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VPN_W-1:0]  lkp_vpn,
   output logic              lkp_hit,
   output logic [PPN_W-1:0]  lkp_ppn,
   output logic [ATTR_W-1:0] lkp_attr,
   input  logic              fill_en,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic [ATTR_W-1:0] fill_attr,
   input  logic              inv_all,
   input  logic              inv_va_en,
   input  logic [VPN_W-1:0]  inv_vpn,
   input  logic              reg_we,
   input  logic [CTRL_W-1:0] reg_wdata,
   output logic [CTRL_W-1:0] reg_rdata
);
   localparam int unsigned VIC_W = $clog2(LD_ENTRIES);

   if (SA_SETS < 2 || (SA_SETS & (SA_SETS - 1)) != 0) begin : g_bad_sets
      $error("SA_SETS must be a power of two, at least 2");
   end
   if (LD_ENTRIES < 2 || (LD_ENTRIES & (LD_ENTRIES - 1)) != 0 || VIC_W > VICTIM_MAX_W) begin : g_bad_ld
      $error("LD_ENTRIES must be a power of two whose index fits the victim field");
   end
   if (SA_WAYS < 1 || VPN_W <= $clog2(SA_SETS)) begin : g_bad_geom
      $error("SA_WAYS must be nonzero and VPN_W wider than the set index");
   end

   logic             place_ld;
   logic [VIC_W-1:0] victim;
   logic             ld_hit, sa_hit;
   logic [PPN_W-1:0] ld_ppn, sa_ppn;
   logic [ATTR_W-1:0] ld_attr, sa_attr;
   logic [SA_WAYS*SA_SETS-1:0] sa_valid;
   logic [LD_ENTRIES-1:0]      ld_valid;

   tlb_lock_ctrl #(.VIC_W(VIC_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
      .place_ld(place_ld), .victim(victim), .rdata(reg_rdata)
   );

   tlb_sa_region #(
      .VPN_W(VPN_W), .PPN_W(PPN_W), .ATTR_W(ATTR_W), .WAYS(SA_WAYS), .SETS(SA_SETS)
   ) u_sa (
      .clk(clk), .rst_n(rst_n), .lkp_vpn(lkp_vpn),
      .hit(sa_hit), .ppn(sa_ppn), .attr(sa_attr),
      .fill_en(fill_en && !place_ld), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_attr(fill_attr), .inv_all(inv_all), .inv_va_en(inv_va_en),
      .inv_vpn(inv_vpn), .valid_flat(sa_valid)
   );

   tlb_ld_region #(
      .VPN_W(VPN_W), .PPN_W(PPN_W), .ATTR_W(ATTR_W), .ENTRIES(LD_ENTRIES)
   ) u_ld (
      .clk(clk), .rst_n(rst_n), .lkp_vpn(lkp_vpn),
      .hit(ld_hit), .ppn(ld_ppn), .attr(ld_attr),
      .fill_en(fill_en && place_ld), .fill_slot(victim), .fill_vpn(fill_vpn),
      .fill_ppn(fill_ppn), .fill_attr(fill_attr), .inv_va_en(inv_va_en),
      .inv_vpn(inv_vpn), .valid(ld_valid)
   );

   assign lkp_hit  = ld_hit | sa_hit;
   assign lkp_ppn  = ld_hit ? ld_ppn  : sa_ppn;
   assign lkp_attr = ld_hit ? ld_attr : sa_attr;
endmodule

// File: rtl/tlb_lockdown_chk.sv
module tlb_lockdown_chk #(
   parameter int unsigned VPN_W      = 20,
   parameter int unsigned PPN_W      = 20,
   parameter int unsigned SA_WAYS    = 2,
   parameter int unsigned SA_SETS    = 16,
   parameter int unsigned LD_ENTRIES = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [VPN_W-1:0]           lkp_vpn,
   input logic                       lkp_hit,
   input logic [PPN_W-1:0]           lkp_ppn,
   input logic                       fill_en,
   input logic [VPN_W-1:0]           fill_vpn,
   input logic                       inv_all,
   input logic                       inv_va_en,
   input logic [VPN_W-1:0]           inv_vpn,
   input logic                       reg_we,
   input logic [31:0]                reg_wdata,
   input logic [31:0]                reg_rdata,
   input logic                       ld_hit,
   input logic [PPN_W-1:0]           ld_ppn,
   input logic [SA_WAYS*SA_SETS-1:0] sa_valid,
   input logic [LD_ENTRIES-1:0]      ld_valid
);
   localparam int unsigned VIC_W = $clog2(LD_ENTRIES);
   localparam logic [31:0] RD_MASK = 32'h1 | (((32'h1 << VIC_W) - 32'h1) << 26);

   p_rdata_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> (reg_rdata == ($past(reg_wdata) & RD_MASK)));

   p_victim_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !reg_we) |=> $stable(reg_rdata));

   p_inv_all_spares_ld_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_all && !fill_en && !inv_va_en) |=> (ld_valid == $past(ld_valid)));

   p_inv_all_empties_sa_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_all && !fill_en) |=> (sa_valid == '0));

   p_inv_va_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_va_en && !fill_en) |=> ((lkp_vpn != $past(inv_vpn)) || !lkp_hit));

   p_ld_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_hit |-> (lkp_hit && (lkp_ppn == ld_ppn)));

   p_fill_survives_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> ((lkp_vpn != $past(fill_vpn)) || lkp_hit));

   p_sa_fill_spares_ld_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !reg_rdata[0] && !inv_va_en) |=> (ld_valid == $past(ld_valid)));
endmodule

bind tlb_lockdown tlb_lockdown_chk #(
   .VPN_W(VPN_W), .PPN_W(PPN_W), .SA_WAYS(SA_WAYS), .SA_SETS(SA_SETS), .LD_ENTRIES(LD_ENTRIES)
) i_chk (
   .clk(clk), .rst_n(rst_n), .lkp_vpn(lkp_vpn), .lkp_hit(lkp_hit), .lkp_ppn(lkp_ppn),
   .fill_en(fill_en), .fill_vpn(fill_vpn), .inv_all(inv_all), .inv_va_en(inv_va_en),
   .inv_vpn(inv_vpn), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .ld_hit(ld_hit), .ld_ppn(ld_ppn), .sa_valid(sa_valid), .ld_valid(ld_valid)
);

// File: tb/test_tlb_lockdown.sv
`timescale 1ns/1ps
module test_tlb_lockdown;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] lkp_vpn = '0;
   logic        lkp_hit;
   logic [19:0] lkp_ppn;
   logic [7:0]  lkp_attr;
   logic        fill_en = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [19:0] fill_ppn = '0;
   logic [7:0]  fill_attr = '0;
   logic        inv_all = 1'b0;
   logic        inv_va_en = 1'b0;
   logic [19:0] inv_vpn = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   always #4 clk = ~clk;

   tlb_lockdown i_tlb_lockdown (.*);

   int n_chk = 0;
   int n_bad = 0;

   // Reference state built from the requirements
   bit          m_sa_v   [16][2];
   logic [19:0] m_sa_vpn [16][2];
   logic [19:0] m_sa_ppn [16][2];
   logic [7:0]  m_sa_at  [16][2];
   int          m_rr     [16];
   bit          m_ld_v   [8];
   logic [19:0] m_ld_vpn [8];
   logic [19:0] m_ld_ppn [8];
   logic [7:0]  m_ld_at  [8];
   bit          m_flag;
   logic [2:0]  m_vic;

   task automatic model_reset();
      for (int s = 0; s < 16; s++) begin
         m_rr[s] = 0;
         for (int w = 0; w < 2; w++) m_sa_v[s][w] = 1'b0;
      end
      for (int e = 0; e < 8; e++) m_ld_v[e] = 1'b0;
      m_flag = 1'b0;
      m_vic  = '0;
   endtask

   task automatic model_lookup(input logic [19:0] v, output bit h,
                               output logic [19:0] p, output logic [7:0] a);
      h = 1'b0; p = '0; a = '0;
      for (int e = 7; e >= 0; e--)
         if (m_ld_v[e] && m_ld_vpn[e] == v) begin h = 1'b1; p = m_ld_ppn[e]; a = m_ld_at[e]; end
      if (!h)
         for (int w = 1; w >= 0; w--)
            if (m_sa_v[v[3:0]][w] && m_sa_vpn[v[3:0]][w] == v) begin
               h = 1'b1; p = m_sa_ppn[v[3:0]][w]; a = m_sa_at[v[3:0]][w];
            end
   endtask

   function automatic logic [31:0] exp_reg();
      logic [31:0] r = '0;
      r[0]     = m_flag;
      r[28:26] = m_vic;
      return r;
   endfunction

   // One clock with any mix of commands; the model follows the R9 ordering.
   task automatic step(input bit f, input logic [19:0] fv, input logic [19:0] fp,
                       input logic [7:0] fa, input bit ia, input bit iv,
                       input logic [19:0] ivv, input bit rw, input logic [31:0] wd);
      fill_en = f; fill_vpn = fv; fill_ppn = fp; fill_attr = fa;
      inv_all = ia; inv_va_en = iv; inv_vpn = ivv; reg_we = rw; reg_wdata = wd;
      @(posedge clk);
      if (ia) for (int s = 0; s < 16; s++) for (int w = 0; w < 2; w++) m_sa_v[s][w] = 1'b0;
      if (iv) begin
         for (int s = 0; s < 16; s++) for (int w = 0; w < 2; w++)
            if (m_sa_v[s][w] && m_sa_vpn[s][w] == ivv) m_sa_v[s][w] = 1'b0;
         for (int e = 0; e < 8; e++)
            if (m_ld_v[e] && m_ld_vpn[e] == ivv) m_ld_v[e] = 1'b0;
      end
      if (f) begin
         if (m_flag) begin
            m_ld_v[m_vic] = 1'b1; m_ld_vpn[m_vic] = fv; m_ld_ppn[m_vic] = fp; m_ld_at[m_vic] = fa;
         end else begin
            int w = m_rr[fv[3:0]];
            m_sa_v[fv[3:0]][w] = 1'b1; m_sa_vpn[fv[3:0]][w] = fv;
            m_sa_ppn[fv[3:0]][w] = fp; m_sa_at[fv[3:0]][w] = fa;
            m_rr[fv[3:0]] = (w + 1) % 2;
         end
      end
      if (rw) begin m_flag = wd[0]; m_vic = wd[28:26]; end
      @(negedge clk);
      fill_en = 1'b0; inv_all = 1'b0; inv_va_en = 1'b0; reg_we = 1'b0;
   endtask

   task automatic do_fill(input logic [19:0] v, input logic [19:0] p, input logic [7:0] a);
      step(1'b1, v, p, a, 1'b0, 1'b0, '0, 1'b0, '0);
   endtask
   task automatic do_reg(input logic [31:0] wd);
      step(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, 1'b1, wd);
   endtask

   task automatic check_lkp(input logic [19:0] v, input string req);
      bit h; logic [19:0] p; logic [7:0] a;
      lkp_vpn = v;
      #1;
      model_lookup(v, h, p, a);
      n_chk++;
      if (lkp_hit !== h || (h && (lkp_ppn !== p || lkp_attr !== a))) begin
         n_bad++;
         $display("FAIL %s vpn=%h actual hit=%b ppn=%h attr=%h expected hit=%b ppn=%h attr=%h",
                  req, v, lkp_hit, lkp_ppn, lkp_attr, h, p, a);
      end
   endtask

   task automatic check_exp(input logic [19:0] v, input bit h, input logic [19:0] p, input string req);
      lkp_vpn = v;
      #1;
      n_chk++;
      if (lkp_hit !== h || (h && lkp_ppn !== p)) begin
         n_bad++;
         $display("FAIL %s vpn=%h actual hit=%b ppn=%h expected hit=%b ppn=%h",
                  req, v, lkp_hit, lkp_ppn, h, p);
      end
   endtask

   task automatic check_reg(input string req);
      #1;
      n_chk++;
      if (reg_rdata !== exp_reg()) begin
         n_bad++;
         $display("FAIL %s reg_rdata actual=%h expected=%h", req, reg_rdata, exp_reg());
      end
   endtask

   function automatic logic [19:0] rnd_vpn();
      return 20'($urandom_range(0, 3) * 16 + $urandom_range(0, 15));
   endfunction

   bit done = 1'b0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1F2E3D4C));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: nothing valid, register clear
      check_exp(20'h00005, 1'b0, '0, "R1");
      check_exp(20'h00000, 1'b0, '0, "R1");
      check_reg("R1");

      // R2: only flag and victim are stored and returned
      do_reg(32'hFFFF_FFFE);
      check_reg("R2");
      n_chk++;
      if (reg_rdata !== 32'h1C00_0000) begin
         n_bad++;
         $display("FAIL R2 reg_rdata actual=%h expected=%h", reg_rdata, 32'h1C00_0000);
      end
      do_reg(32'h0);

      // R3: round-robin eviction inside set 3
      do_fill(20'h00013, 20'hA0013, 8'h11);
      do_fill(20'h00023, 20'hA0023, 8'h12);
      do_fill(20'h00033, 20'hA0033, 8'h13);
      check_exp(20'h00013, 1'b0, '0, "R3");
      check_exp(20'h00023, 1'b1, 20'hA0023, "R3");
      check_exp(20'h00033, 1'b1, 20'hA0033, "R3");

      // R4 and R5: pinned slot 2 overwritten, victim does not move
      do_reg(32'h0800_0001);
      do_fill(20'h00044, 20'hB0044, 8'h21);
      check_reg("R5");
      do_fill(20'h00055, 20'hB0055, 8'h22);
      check_reg("R5");
      check_exp(20'h00044, 1'b0, '0, "R4");
      check_exp(20'h00055, 1'b1, 20'hB0055, "R4");
      check_exp(20'h00023, 1'b1, 20'hA0023, "R4");

      // R8: pinned copy wins over an array copy of the same page
      do_reg(32'h0);
      do_fill(20'h00055, 20'hC0055, 8'h33);
      check_exp(20'h00055, 1'b1, 20'hB0055, "R8");

      // R6: flush-all keeps pinned entries
      step(1'b0, '0, '0, '0, 1'b1, 1'b0, '0, 1'b0, '0);
      check_exp(20'h00055, 1'b1, 20'hB0055, "R6");
      check_exp(20'h00023, 1'b0, '0, "R6");

      // R7: flush-by-address removes copies from both stores
      do_fill(20'h00055, 20'hC0055, 8'h33);
      step(1'b0, '0, '0, '0, 1'b0, 1'b1, 20'h00055, 1'b0, '0);
      check_exp(20'h00055, 1'b0, '0, "R7");

      // R9: flush and refill together; register write and refill together
      step(1'b1, 20'h00077, 20'hD0077, 8'h44, 1'b1, 1'b0, '0, 1'b0, '0);
      check_exp(20'h00077, 1'b1, 20'hD0077, "R9");
      step(1'b1, 20'h00088, 20'hD0088, 8'h45, 1'b0, 1'b0, '0, 1'b1, 32'h0000_0001);
      check_exp(20'h00088, 1'b1, 20'hD0088, "R9");
      step(1'b0, '0, '0, '0, 1'b1, 1'b0, '0, 1'b0, '0);
      check_exp(20'h00088, 1'b0, '0, "R9");

      // R10: pinned entry survives heavy pressure on its set
      do_reg(32'h0000_0001);
      do_fill(20'h00099, 20'hE0099, 8'h55);
      do_reg(32'h0);
      for (int i = 0; i < 40; i++) do_fill(20'((i + 16) * 16 + 9), 20'(i), 8'(i));
      check_exp(20'h00099, 1'b1, 20'hE0099, "R10");

      // Random mix against the reference state
      for (int i = 0; i < 4000; i++) begin
         int op = $urandom_range(0, 19);
         if (op < 10)      do_fill(rnd_vpn(), 20'($urandom()), 8'($urandom()));
         else if (op < 14) step(1'b0, '0, '0, '0, 1'b0, 1'b1, rnd_vpn(), 1'b0, '0);
         else if (op < 15) step(1'b0, '0, '0, '0, 1'b1, 1'b0, '0, 1'b0, '0);
         else if (op < 18) do_reg($urandom());
         else step(1'b1, rnd_vpn(), 20'($urandom()), 8'($urandom()),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), rnd_vpn(),
                   1'($urandom_range(0, 1)), $urandom());
         check_lkp(rnd_vpn(), "R8");
         check_lkp(rnd_vpn(), "R7");
         check_reg("R2");
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule